// File: doc/BRIEF.md
# Banked ROM and RAM Address Decoder

This block decodes the 16-bit address bus of an 8-bit processor into chip selects for a banked ROM, a work RAM and an I/O register window. The ROM store is 128 KB, built from two 64 KB devices. Any one 32 KB half of either device can be placed in the upper half of the processor map, 0x8000-0xFFFF. That gives four banks, and the interrupt and reset vectors at the top of the map always come from the bank that is live at the time. The bank number is held in a two-bit register. The processor writes that register at a fixed address inside the I/O window.

Work RAM is 8 KB. At the bottom of the map only its first 2 KB can be reached, because the I/O window begins right above it. In banks one, two and three the whole 8 KB also appears at 0x8000-0x9FFF. There it wins over ROM, so the processor can reach all of the RAM. In the default bank (bank zero) that window reads ROM as usual. Software changes banks by writing the register and fetching its next instruction from the new bank.

The bank register is a four-state machine: BANK_DEFAULT, BANK_ONE, BANK_TWO and BANK_THREE. It has one kind of transition, a select write. A write strobe at the bank register address moves the machine to the state given by data bits [1:0], and it may move to any state, including the current one. With no such write, each state holds. Reset forces BANK_DEFAULT.

Top module: `bank_decoder`

## Requirements
- R1: After reset the bank is zero, so an access to 0xFFFE selects ROM with extended address 0x07FFE.
- R2: Addresses 0x0000-0x07FF assert only ram_sel, with ram_xaddr equal to addr[12:0].
- R3: Addresses 0x0800-0x0FFF assert only io_sel.
- R4: In bank zero every address in 0x8000-0xFFFF asserts only rom_sel. The 17-bit rom_xaddr is arranged as bit 16 = device select (bank bit 1), bit 15 = half select (bank bit 0), and bits 14:0 = addr[14:0]. This arrangement holds in every bank.
- R5: In banks one to three, addresses 0x8000-0x9FFF assert only ram_sel, with ram_xaddr equal to addr[12:0]. Addresses 0xA000-0xFFFF still select ROM.
- R6: The vector addresses 0xFFF8-0xFFFF select ROM in the bank that is currently live.
- R7: A cycle with wr_en high and addr equal to 0x0FC0 loads wdata[1:0] as the bank number. While that write cycle is on the bus, decoding still uses the old bank. Decoding uses the new bank from the following cycle onward.
- R8: A write to any other address, or a cycle with wr_en low, leaves the bank unchanged.
- R9: At most one of rom_sel, ram_sel and io_sel is high for any address. Addresses 0x1000-0x7FFF assert none of them.
- R10: Bits [7:2] of wdata have no effect on the bank chosen by a bank write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 8 | Processor write data |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 1 | RAM chip select, for the low region and the alias window |
| io_sel | output | 1 | I/O register window select |
| rom_xaddr | output | 17 | Extended ROM address: {device, half, addr[14:0]} |
| ram_xaddr | output | 13 | Address presented to the 8 KB RAM |

## Verification
If the bank state is wrong, the fault shows up in the same cycle on rom_xaddr bits 16:15, and it does so for every address. The upper ROM region also flips between the RAM alias and ROM when the state is wrong. A bank load taken one cycle early shows as the new bank during the write cycle itself. A load taken one cycle late, or one that wrongly takes data bits above bit 1, shows on the first probe after the write. A stray load from a non-bank write shows on the first probe after that write. A fault in the region boundaries shows as a wrong or doubled chip select, but only at the edge addresses themselves. For that reason the edges are probed directly in every bank, as well as through random sweeps.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;
    typedef enum logic [1:0] {
        BANK_DEFAULT = 2'd0,
        BANK_ONE     = 2'd1,
        BANK_TWO     = 2'd2,
        BANK_THREE   = 2'd3
    } bank_state_e;

    typedef enum logic [1:0] {
        REGION_NONE,
        REGION_RAM,
        REGION_IO,
        REGION_ROM
    } region_e;
endpackage

// File: rtl/bank_fsm.sv
module bank_fsm
    import bankdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] sel,
    output logic       dev_bit,
    output logic       half_bit,
    output logic       alias_en
);
    bank_state_e state_q, state_d;

    // next state: select write jumps to any state, otherwise hold
    always_comb begin
        state_d = state_q;
        if (load) begin
            unique case (sel)
                2'd0: state_d = BANK_DEFAULT;
                2'd1: state_d = BANK_ONE;
                2'd2: state_d = BANK_TWO;
                2'd3: state_d = BANK_THREE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BANK_DEFAULT;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            BANK_DEFAULT: begin dev_bit = 1'b0; half_bit = 1'b0; alias_en = 1'b0; end
            BANK_ONE:     begin dev_bit = 1'b0; half_bit = 1'b1; alias_en = 1'b1; end
            BANK_TWO:     begin dev_bit = 1'b1; half_bit = 1'b0; alias_en = 1'b1; end
            BANK_THREE:   begin dev_bit = 1'b1; half_bit = 1'b1; alias_en = 1'b1; end
        endcase
    end
endmodule

// File: rtl/map_decode.sv
module map_decode
    import bankdec_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int LOW_RAM_TOP = 32'h0800,
    parameter int IO_TOP      = 32'h1000,
    parameter int ROM_BASE    = 32'h8000,
    parameter int ALIAS_TOP   = 32'hA000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              alias_en,
    output region_e           region
);
    logic [31:0] a32;
    assign a32 = 32'(addr);

    always_comb begin
        if (a32 < 32'(LOW_RAM_TOP))
            region = REGION_RAM;
        else if (a32 < 32'(IO_TOP))
            region = REGION_IO;
        else if (a32 < 32'(ROM_BASE))
            region = REGION_NONE;
        else if (alias_en && (a32 < 32'(ALIAS_TOP)))
            region = REGION_RAM;
        else
            region = REGION_ROM;
    end
endmodule

// File: rtl/select_drive.sv
module select_drive
    import bankdec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 15,
    parameter int RAM_AW = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  region_e           region,
    input  logic              dev_bit,
    input  logic              half_bit,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic              io_sel,
    output logic [OFF_W+1:0]  rom_xaddr,
    output logic [RAM_AW-1:0] ram_xaddr
);
    always_comb begin
        rom_sel = 1'b0;
        ram_sel = 1'b0;
        io_sel  = 1'b0;
        unique case (region)
            REGION_NONE: ;
            REGION_RAM:  ram_sel = 1'b1;
            REGION_IO:   io_sel  = 1'b1;
            REGION_ROM:  rom_sel = 1'b1;
        endcase
    end

    assign rom_xaddr = {dev_bit, half_bit, addr[OFF_W-1:0]};
    assign ram_xaddr = addr[RAM_AW-1:0];
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import bankdec_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int RAM_BYTES   = 8192,
    parameter int LOW_RAM_TOP = 32'h0800,
    parameter int IO_TOP      = 32'h1000,
    parameter int BANK_REG    = 32'h0FC0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         addr,
    input  logic                wr_en,
    input  logic [7:0]          wdata,
    output logic                rom_sel,
    output logic                ram_sel,
    output logic                io_sel,
    output logic [16:0]         rom_xaddr,
    output logic [12:0]         ram_xaddr
);
    localparam int OFF_W     = ADDR_W - 1;
    localparam int RAM_AW    = $clog2(RAM_BYTES);
    localparam int ROM_BASE  = 1 << OFF_W;
    localparam int ALIAS_TOP = ROM_BASE + RAM_BYTES;

    logic    bank_load;
    logic    dev_bit, half_bit, alias_en;
    region_e region;

    assign bank_load = wr_en && (32'(addr) == 32'(BANK_REG));

    bank_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bank_load),
        .sel      (wdata[1:0]),
        .dev_bit  (dev_bit),
        .half_bit (half_bit),
        .alias_en (alias_en)
    );

    map_decode #(
        .ADDR_W      (ADDR_W),
        .LOW_RAM_TOP (LOW_RAM_TOP),
        .IO_TOP      (IO_TOP),
        .ROM_BASE    (ROM_BASE),
        .ALIAS_TOP   (ALIAS_TOP)
    ) u_map (
        .addr     (addr),
        .alias_en (alias_en),
        .region   (region)
    );

    select_drive #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .RAM_AW (RAM_AW)
    ) u_sel (
        .addr      (addr),
        .region    (region),
        .dev_bit   (dev_bit),
        .half_bit  (half_bit),
        .rom_sel   (rom_sel),
        .ram_sel   (ram_sel),
        .io_sel    (io_sel),
        .rom_xaddr (rom_xaddr),
        .ram_xaddr (ram_xaddr)
    );
endmodule

// File: rtl/bank_decoder_checker.sv
module bank_decoder_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        wr_en,
    input logic [7:0]  wdata,
    input logic        rom_sel,
    input logic        ram_sel,
    input logic        io_sel,
    input logic [16:0] rom_xaddr
);
    logic bank_wr;
    assign bank_wr = wr_en && (addr == 16'h0FC0);

    assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, ram_sel, io_sel}));

    assert_bank_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> (rom_xaddr[16:15] == $past(wdata[1:0])));

    assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> (rom_xaddr[16:15] == $past(rom_xaddr[16:15])));

    assert_alias_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:13] == 3'b100 && rom_xaddr[16:15] != 2'b00) |-> (ram_sel && !rom_sel));

    assert_bank0_rom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15] && rom_xaddr[16:15] == 2'b00) |-> rom_sel);

    assert_io_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:11] == 5'b00001) |-> io_sel);
endmodule

bind bank_decoder bank_decoder_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .rom_sel   (rom_sel),
    .ram_sel   (ram_sel),
    .io_sel    (io_sel),
    .rom_xaddr (rom_xaddr)
);

// File: tb/bank_decoder_test.sv
module bank_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic        wr_en;
    logic [7:0]  wdata;
    logic        rom_sel, ram_sel, io_sel;
    logic [16:0] rom_xaddr;
    logic [12:0] ram_xaddr;

    int   n_checks = 0;
    int   n_err    = 0;
    bit   done     = 1'b0;
    logic [1:0] exp_bank;

    always #2 clk = ~clk;

    bank_decoder uut (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en), .wdata (wdata),
        .rom_sel (rom_sel), .ram_sel (ram_sel), .io_sel (io_sel),
        .rom_xaddr (rom_xaddr), .ram_xaddr (ram_xaddr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // expected selects {rom, ram, io} from the requirements
    function automatic logic [2:0] exp_sel(input logic [15:0] a, input logic [1:0] b);
        if (a < 16'h0800)                     return 3'b010;
        else if (a < 16'h1000)                return 3'b001;
        else if (a < 16'h8000)                return 3'b000;
        else if (b != 2'b00 && a < 16'hA000)  return 3'b010;
        else                                  return 3'b100;
    endfunction

    function automatic string tag_of(input logic [15:0] a, input logic [1:0] b);
        if (a < 16'h0800)                     return "R2";
        else if (a < 16'h1000)                return "R3";
        else if (a < 16'h8000)                return "R9";
        else if (b != 2'b00 && a < 16'hA000)  return "R5";
        else if (a >= 16'hFFF8)               return "R6";
        else                                  return "R4";
    endfunction

    task automatic probe(input logic [15:0] a);
        logic [2:0]  es;
        logic [16:0] ex;
        string       t;
        @(negedge clk);
        addr  = a;
        wr_en = 1'b0;
        #1;
        es = exp_sel(a, exp_bank);
        ex = {exp_bank, a[14:0]};
        t  = tag_of(a, exp_bank);
        chk({rom_sel, ram_sel, io_sel} == es, t, 32'({rom_sel, ram_sel, io_sel}), 32'(es));
        chk($countones({rom_sel, ram_sel, io_sel}) <= 1, "R9", 32'({rom_sel, ram_sel, io_sel}), 32'(es));
        chk(rom_xaddr == ex, "R4", 32'(rom_xaddr), 32'(ex));
        if (es == 3'b010)
            chk(ram_xaddr == a[12:0], t, 32'(ram_xaddr), 32'(a[12:0]));
    endtask

    task automatic set_bank(input logic [1:0] b, input logic [5:0] junk);
        @(negedge clk);
        addr  = 16'h0FC0;
        wr_en = 1'b1;
        wdata = {junk, b};
        #1;
        chk(rom_xaddr[16:15] == exp_bank, "R7", 32'(rom_xaddr[16:15]), 32'(exp_bank));
        chk(io_sel == 1'b1, "R3", 32'(io_sel), 32'd1);
        @(posedge clk);
        exp_bank = b;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk(rom_xaddr[16:15] == b, (junk != 0) ? "R10" : "R7", 32'(rom_xaddr[16:15]), 32'(b));
    endtask

    task automatic stray_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wr_en = 1'b1;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        addr  = 16'hFFFE;
        #1;
        chk(rom_xaddr[16:15] == exp_bank, "R8", 32'(rom_xaddr[16:15]), 32'(exp_bank));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] corners [11];
        corners = '{16'h0000, 16'h07FF, 16'h0800, 16'h0FFF, 16'h1000, 16'h7FFF,
                    16'h8000, 16'h9FFF, 16'hA000, 16'hFFF8, 16'hFFFF};
        void'($urandom(32'd2467));
        rst_n = 1'b0; addr = 16'h0000; wr_en = 1'b0; wdata = 8'h00;
        exp_bank = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset bank and reset vector location
        addr = 16'hFFFE;
        #1;
        chk(rom_sel == 1'b1, "R1", 32'(rom_sel), 32'd1);
        chk(rom_xaddr == 17'h07FFE, "R1", 32'(rom_xaddr), 32'h07FFE);

        for (int b = 0; b < 4; b++) begin
            if (b != 0) set_bank(2'(b), 6'd0);
            foreach (corners[i]) probe(corners[i]);
            for (int k = 0; k < 150; k++) probe(16'($urandom));
            for (int k = 0; k < 20; k++) probe(16'h8000 | 16'($urandom_range(0, 16'h1FFF)));
        end

        // R8: writes elsewhere and idle cycles keep the bank
        stray_write(16'h0FC1, 8'h00);
        stray_write(16'h8000, 8'h01);
        stray_write(16'h0000, 8'h02);
        stray_write(16'hFFC0, 8'h00);
        @(negedge clk);
        addr = 16'h0FC0; wdata = 8'h00; wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(rom_xaddr[16:15] == exp_bank, "R8", 32'(rom_xaddr[16:15]), 32'(exp_bank));

        // R10: upper data bits ignored
        set_bank(2'b01, 6'h3F);
        probe(16'h9000);
        set_bank(2'b00, 6'h2A);
        probe(16'h9000);
        probe(16'hFFFA);
        set_bank(2'b10, 6'h15);
        probe(16'hFFFC);

        // back-to-back bank writes
        set_bank(2'b11, 6'd0);
        set_bank(2'b00, 6'd0);
        probe(16'h8001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule